// File: doc/BRIEF.md
# Slow-Clock Timer with Cross-Domain Register Writes

This block is an 8-bit timer/counter whose count can advance on the rising edges of a slow timer clock. Software reaches it from the fast system clock domain. Software writes the counter, the compare value and the control word through separate holding registers. Each written value reaches its working register only after two rising edges of the slow clock. Until that happens, a busy bit for that register reads as one.

The slow clock is brought in through a three-flop sampler that runs on the system clock. Each rising edge of the slow clock becomes a one-cycle event in the system domain. This sampler is the crossing between the two domains. For it to work, the system clock must run at more than four times the slow clock.

A control bit picks the count source: either every system clock cycle, or every slow-clock rising edge. There are two counting modes. In normal mode the counter wraps from 255 to 0 and raises an overflow flag. In clear-on-compare mode the counter returns to 0 at the compare value and raises the compare flag. While a counter write or a compare write is still pending, compare matching is turned off.

Top module: `async_timer_bridge`

## Requirements
- R1: After reset, the counter, the compare value, the control word, both flags and all three busy bits are zero.
- R2: An accepted write sets a busy bit on the next system clock edge. The write goes to address 0 (counter, busy bit 0), address 1 (compare, busy bit 1) or address 2 (control, busy bit 2). After one slow-clock rising edge, the working register still holds its old value. On the second slow-clock rising edge, the working register takes the written value and the busy bit clears.
- R3: The three registers have separate holding registers, so back-to-back writes to different addresses both arrive intact.
- R4: A write to an address whose busy bit is set is ignored, and the earlier pending value is the one that lands.
- R5: The control word has three bits. Bit 2 is run: when 0, the counter holds. Bit 0 is the source: 0 counts once per system clock, 1 counts once per slow-clock rising edge. Bit 1 selects clear-on-compare mode. On the edge where a new control word lands, the count step still follows the old word.
- R6: In clear-on-compare mode, a count step taken while the counter equals the compare value loads 0 and sets the compare flag on the same edge. The counter therefore runs through TOP-1, TOP, 0, 1.
- R7: In normal mode, a count step at 255 wraps to 0 and sets the overflow flag. A count step while the counter equals the compare value sets the compare flag without clearing the counter.
- R8: While busy bit 0 or busy bit 1 is set, no compare match takes place. The compare flag is not set and the counter is not cleared; it steps on by one.
- R9: Writing address 3 clears the compare flag where data bit 0 is 1 and the overflow flag where data bit 1 is 1. A zero bit leaves its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_clk | input | 1 | Slow timer clock, sampled in the system domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 counter, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current counter value |
| busy_o | output | 3 | Update-pending bits: counter, compare, control |
| cmp_flag_o | output | 1 | Compare-match flag |
| ovf_flag_o | output | 1 | Overflow flag |

## Verification
The hardest case to reach is a compare match that would happen but is suppressed. The counter must sit exactly on the compare value on the same slow-clock edge where a compare write is still in flight. To get there, the stimulus loads the counter one below the compare value while the counter runs. It then rewrites the compare register with its current value. The first slow edge steps the counter onto the compare value, and the second slow edge lands the rewrite. The bench checks that the counter stepped on and that no flag was raised. The slow clock is driven by hand, one pulse at a time, so every step of the two-edge transfer can be observed.

// File: rtl/async_timer_bridge.sv
module async_timer_bridge #(
  parameter int W = 8
) (
  input  logic         sys_clk,
  input  logic         rst_n,
  input  logic         tmr_clk,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic [2:0]   busy_o,
  output logic         cmp_flag_o,
  output logic         ovf_flag_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [2:0]   tsamp;
  logic         tmr_rise;
  logic [W-1:0] hold_cnt, hold_cmp;
  logic [2:0]   hold_ctl;
  logic [2:0]   busy, half, wr_hit, done;
  logic [W-1:0] cnt, cmp;
  logic [2:0]   ctl;
  logic         cmpf, ovff;
  logic         tick, cmp_hit, ovf_hit, clr_wr;

  assign tmr_rise = tsamp[1] & ~tsamp[2];

  always_comb
    for (int i = 0; i < 3; i++)
      wr_hit[i] = wr_en && (wr_addr == i[1:0]) && !busy[i];

  assign done    = busy & half & {3{tmr_rise}};
  assign tick    = ctl[2] & (ctl[0] ? tmr_rise : 1'b1);
  assign cmp_hit = tick & ~busy[0] & ~busy[1] & (cnt == cmp);
  assign ovf_hit = tick & ~ctl[1] & (cnt == TOP);
  assign clr_wr  = wr_en && (wr_addr == 2'd3);

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) tsamp <= '0;
    else        tsamp <= {tsamp[1:0], tmr_clk};

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      busy <= '0;
      half <= '0;
    end else begin
      for (int i = 0; i < 3; i++)
        if (wr_hit[i]) begin
          busy[i] <= 1'b1;
          half[i] <= 1'b0;
        end else if (busy[i] && tmr_rise) begin
          if (half[i]) busy[i] <= 1'b0;
          else         half[i] <= 1'b1;
        end
    end

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      hold_cnt <= '0;
      hold_cmp <= '0;
      hold_ctl <= '0;
    end else begin
      if (wr_hit[0]) hold_cnt <= wr_data;
      if (wr_hit[1]) hold_cmp <= wr_data;
      if (wr_hit[2]) hold_ctl <= wr_data[2:0];
    end

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      cmp  <= '0;
      ctl  <= '0;
      cmpf <= 1'b0;
      ovff <= 1'b0;
    end else begin
      if (done[0])                cnt <= hold_cnt;
      else if (cmp_hit && ctl[1]) cnt <= '0;
      else if (tick)              cnt <= cnt + 1'b1;
      if (done[1]) cmp <= hold_cmp;
      if (done[2]) ctl <= hold_ctl;
      cmpf <= cmp_hit | (cmpf & ~(clr_wr & wr_data[0]));
      ovff <= ovf_hit | (ovff & ~(clr_wr & wr_data[1]));
    end

  assign count_o    = cnt;
  assign busy_o     = busy;
  assign cmp_flag_o = cmpf;
  assign ovf_flag_o = ovff;
endmodule

// File: rtl/async_timer_bridge_chk.sv
module async_timer_bridge_chk #(
  parameter int W = 8
) (
  input logic         sys_clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] count_o,
  input logic [2:0]   busy_o,
  input logic         cmp_flag_o,
  input logic         ovf_flag_o,
  input logic         tmr_rise,
  input logic [W-1:0] hold_cnt
);
  assert_busy_cnt_from_write_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(busy_o[0]) |-> $past(wr_en && wr_addr == 2'd0));
  assert_busy_cmp_from_write_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(busy_o[1]) |-> $past(wr_en && wr_addr == 2'd1));
  assert_busy_ctl_from_write_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(busy_o[2]) |-> $past(wr_en && wr_addr == 2'd2));
  assert_busy_clears_on_edge_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(busy_o[0]) |-> $past(tmr_rise));
  assert_busy_write_ignored_R4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (busy_o[0] && wr_en && wr_addr == 2'd0) |=> $stable(hold_cnt));
  assert_match_gated_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(cmp_flag_o) |-> $past(busy_o[1:0] == 2'b00));
  assert_ovf_at_top_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> $past(count_o) == {W{1'b1}});
endmodule

bind async_timer_bridge async_timer_bridge_chk #(.W(W)) chk_i (
  .sys_clk(sys_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .count_o(count_o), .busy_o(busy_o), .cmp_flag_o(cmp_flag_o),
  .ovf_flag_o(ovf_flag_o), .tmr_rise(tmr_rise), .hold_cnt(hold_cnt)
);

// File: tb/async_timer_bridge_test.sv
module async_timer_bridge_test;
  logic       sys_clk = 1'b0;
  logic       rst_n, tmr_clk, wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data, count_o;
  logic [2:0] busy_o;
  logic       cmp_flag_o, ovf_flag_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  async_timer_bridge uut (.*);

  always #2 sys_clk = ~sys_clk;

  // {start, compare, clear_on_compare, steps}
  localparam logic [24:0] VEC [6] = '{
    {8'd1,   8'd3,   1'b1, 8'd3},
    {8'd1,   8'd3,   1'b1, 8'd2},
    {8'd250, 8'd100, 1'b0, 8'd8},
    {8'd0,   8'd5,   1'b1, 8'd13},
    {8'd10,  8'd12,  1'b0, 8'd5},
    {8'd254, 8'd255, 1'b1, 8'd3}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge sys_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge sys_clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge sys_clk); tmr_clk = 1'b1;
      repeat (3) @(negedge sys_clk);
      tmr_clk = 1'b0;
      repeat (3) @(negedge sys_clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge sys_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] a;
    rst_n = 1'b0; tmr_clk = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge sys_clk);
    rst_n = 1'b1;
    @(negedge sys_clk);
    check("R1 count", count_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 flags", {cmp_flag_o, ovf_flag_o}, 0);

    foreach (VEC[v]) begin
      logic [7:0] st, cp, c;
      logic ctc, ecf, eof;
      int n;
      {st, cp, ctc} = VEC[v][24:8];
      n = int'(VEC[v][7:0]);
      wr(2, 8'h01); wr(0, st); wr(1, cp);
      pulse(2);
      wr(3, 8'h03);
      wr(2, {5'd0, 1'b1, ctc, 1'b1});
      pulse(2);
      c = st; ecf = 0; eof = 0;
      for (int k = 0; k < n; k++) begin
        if (c == cp) ecf = 1;
        if (ctc && c == cp) c = 8'd0;
        else begin
          if (!ctc && c == 8'hFF) eof = 1;
          c = c + 8'd1;
        end
      end
      pulse(n);
      check(ctc ? "R6 count" : "R7 count", count_o, c);
      check(ctc ? "R6 cmp flag" : "R7 cmp flag", cmp_flag_o, ecf);
      check("R7 ovf flag", ovf_flag_o, eof);
    end

    wr(2, 8'h01); pulse(2);
    wr(0, 8'h33); pulse(2);
    wr(0, 8'h40);
    check("R2 busy set", busy_o, 3'b001);
    pulse(1);
    check("R2 busy after one edge", busy_o, 3'b001);
    check("R2 old value after one edge", count_o, 8'h33);
    pulse(1);
    check("R2 busy cleared", busy_o, 3'b000);
    check("R2 value landed", count_o, 8'h40);

    wr(0, 8'h11); wr(0, 8'h22);
    pulse(2);
    check("R4 second write ignored", count_o, 8'h11);

    wr(0, 8'h50); wr(1, 8'h52);
    check("R3 both busy", busy_o, 3'b011);
    pulse(2);
    check("R3 counter landed", count_o, 8'h50);
    wr(2, 8'h07); pulse(2);
    wr(3, 8'h03);
    pulse(2);
    check("R5 counts on slow edges", count_o, 8'h52);
    pulse(1);
    check("R3 compare landed, R6 wrap", count_o, 8'h00);
    check("R6 flag at wrap", cmp_flag_o, 1);

    wr(3, 8'h02);
    check("R9 zero bit keeps flag", cmp_flag_o, 1);
    wr(3, 8'h01);
    check("R9 one bit clears flag", cmp_flag_o, 0);

    wr(0, 8'h51); pulse(2);
    wr(1, 8'h52); pulse(2);
    check("R8 counter steps past", count_o, 8'h53);
    check("R8 no flag while busy", cmp_flag_o, 0);

    wr(2, 8'h04); pulse(2);
    @(negedge sys_clk); a = count_o;
    @(negedge sys_clk);
    check("R5 system clock source", count_o, a + 8'd1);
    wr(2, 8'h00); pulse(2);
    @(negedge sys_clk); a = count_o;
    pulse(1);
    check("R5 run off holds", count_o, a);
    finish_run();
  end
endmodule